// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block turns a 16-bit half-precision floating-point value into a 32-bit single-precision value. Every half value has an exact single-precision image, so no rounding logic exists. Subnormal half inputs are renormalised into single-precision normals. A mode input selects how the top exponent code is read. In standard IEEE mode it encodes infinities and NaNs. In the alternative mode it is an ordinary exponent, which buys one extra binade of range.

A default-NaN control replaces every NaN result with the canonical quiet NaN. A signalling NaN input raises the invalid flag. The result and the flag are registered once, so they appear one clock after the input. A parameter can make the path purely combinational. All field widths are parameters, and the default is 5/10 in and 8/23 out.

Top module: `hcvt_widen`

## Requirements
- R1: Input bit 15 is the sign, bits 14:10 the biased exponent (bias 15) and bits 9:0 the fraction. Output bit 31 is the sign, bits 30:23 the exponent (bias 127) and bits 22:0 the fraction. A normal input gets exponent+112 and a fraction shifted left by 13 bits (0x3C00 gives 0x3F800000).
- R2: A zero input of either sign gives a zero of the same sign (0x8000 gives 0x80000000) in both modes.
- R3: A subnormal input (exponent 0, fraction nonzero) gives the exact single-precision normal. 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R4: In IEEE mode (alternative-mode input low), exponent 31 with a zero fraction gives infinity of the same sign (0x7F800000 / 0xFF800000) and does not raise invalid.
- R5: In alternative mode, exponent 31 is a normal exponent (output exponent 143). 0x7FFF gives 0x47FFE000 (131008.0). No result in this mode has output exponent 255, and none raises invalid.
- R6: In IEEE mode, a NaN input with fraction bit 9 set (quiet) gives, when default-NaN is low, the same sign, exponent 255 and the fraction left-aligned (bit 22 set). When default-NaN is high it gives 0x7FC00000. Neither case raises invalid.
- R7: In IEEE mode, a NaN input with fraction bit 9 clear (signalling) raises invalid. The result is the input NaN quieted by setting bit 22 when default-NaN is low, and 0x7FC00000 when default-NaN is high.
- R8: Invalid is never raised for any other input. With the output register enabled, the result and flag appear one clock after the input, and they are zero during and straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_i | input | 16 | Half-precision operand |
| alt_i | input | 1 | 1 selects the alternative encoding with no infinity or NaN |
| dnan_i | input | 1 | 1 replaces any NaN result with the default quiet NaN |
| word_o | output | 32 | Single-precision result |
| invalid_o | output | 1 | Invalid-operation flag for a signalling NaN input |

## Verification
The bench goes after the edges of the exponent range.

- A mistake in the shift or exponent adjustment for subnormals shows up in the smallest subnormal, the largest subnormal and the smallest normal.
- An alternative-mode path that still decodes exponent 31 as special turns 0x7FFF into a NaN instead of 131008.0.
- NaN handling is probed in quiet and signalling form, in both signs, with and without default-NaN. A design that mixes these up drops the quiet bit, keeps the sign under default-NaN, or misplaces the invalid flag.
- An exhaustive sweep of every code in both modes compares against a bench model that normalises by iterative shifting.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_QNAN = 3'd4,
      CLS_SNAN = 3'd5
   } hcls_e;

   function automatic int bias_of(input int ew);
      return (1 << (ew - 1)) - 1;
   endfunction

endpackage

// File: rtl/hcvt_unpack.sv
module hcvt_unpack
   import hcvt_pkg::*;
#(
   parameter int EXP_W  = 5,
   parameter int FRAC_W = 10
) (
   input  logic [EXP_W+FRAC_W:0] half_i,
   input  logic                  alt_i,
   output logic                  sign_o,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W-1:0]     frac_o,
   output hcls_e                 cls_o
);

   logic exp_ones, exp_none, frac_none;

   assign sign_o = half_i[EXP_W+FRAC_W];
   assign exp_o  = half_i[EXP_W+FRAC_W-1 -: EXP_W];
   assign frac_o = half_i[FRAC_W-1:0];

   assign exp_ones  = &exp_o;
   assign exp_none  = ~|exp_o;
   assign frac_none = ~|frac_o;

   always_comb begin
      if (exp_none) begin
         cls_o = frac_none ? CLS_ZERO : CLS_SUB;
      end else if (exp_ones && !alt_i) begin
         if (frac_none)                cls_o = CLS_INF;
         else if (frac_o[FRAC_W-1])    cls_o = CLS_QNAN;
         else                          cls_o = CLS_SNAN;
      end else begin
         cls_o = CLS_NORM;
      end
   end

endmodule

// File: rtl/hcvt_lzc.sv
module hcvt_lzc #(
   parameter int W  = 10,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o,
   output logic          zero_o
);

   logic [W-1:0] hit;

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_pref
         assign hit[gi] = |vec_i[W-1:gi];
      end
   endgenerate

   always_comb begin
      cnt_o = '0;
      for (int k = 0; k < W; k++) begin
         cnt_o = cnt_o + CW'(!hit[k]);
      end
   end

   assign zero_o = ~hit[0];

endmodule

// File: rtl/hcvt_pack.sv
module hcvt_pack
   import hcvt_pkg::*;
#(
   parameter int IEW = 5,
   parameter int IFW = 10,
   parameter int OEW = 8,
   parameter int OFW = 23,
   parameter int LZW = 4
) (
   input  logic             sign_i,
   input  logic [IEW-1:0]   exp_i,
   input  logic [IFW-1:0]   frac_i,
   input  hcls_e            cls_i,
   input  logic [LZW-1:0]   lz_i,
   input  logic             dnan_i,
   output logic [OEW+OFW:0] word_o,
   output logic             invalid_o
);

   localparam int IBIAS = bias_of(IEW);
   localparam int OBIAS = bias_of(OEW);
   localparam int BD    = OBIAS - IBIAS;
   localparam int FSH   = OFW - IFW;

   logic           osign;
   logic [OEW-1:0] oexp;
   logic [OFW-1:0] ofrac;
   logic [IFW:0]   shifted;
   logic [OEW-1:0] sub_exp;
   logic [OEW-1:0] norm_exp;

   assign shifted  = {1'b0, frac_i} << ({1'b0, lz_i} + (LZW+1)'(1));
   assign sub_exp  = OEW'(BD) - OEW'(lz_i);
   assign norm_exp = OEW'(exp_i) + OEW'(BD);

   always_comb begin
      osign = sign_i;
      oexp  = '0;
      ofrac = '0;
      unique case (cls_i)
         CLS_ZERO: begin
            oexp  = '0;
            ofrac = '0;
         end
         CLS_SUB: begin
            oexp  = sub_exp;
            ofrac = {shifted[IFW-1:0], {FSH{1'b0}}};
         end
         CLS_NORM: begin
            oexp  = norm_exp;
            ofrac = {frac_i, {FSH{1'b0}}};
         end
         CLS_INF: begin
            oexp  = '1;
            ofrac = '0;
         end
         CLS_QNAN, CLS_SNAN: begin
            oexp = '1;
            if (dnan_i) begin
               osign = 1'b0;
               ofrac = {1'b1, {(OFW-1){1'b0}}};
            end else begin
               ofrac = {1'b1, frac_i[IFW-2:0], {FSH{1'b0}}};
            end
         end
         default: begin
            oexp  = '0;
            ofrac = '0;
         end
      endcase
   end

   assign word_o    = {osign, oexp, ofrac};
   assign invalid_o = (cls_i == CLS_SNAN);

endmodule

// File: rtl/hcvt_widen.sv
module hcvt_widen
   import hcvt_pkg::*;
#(
   parameter int IN_EXP_W   = 5,
   parameter int IN_FRAC_W  = 10,
   parameter int OUT_EXP_W  = 8,
   parameter int OUT_FRAC_W = 23,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IN_EXP_W+IN_FRAC_W:0]   half_i,
   input  logic                          alt_i,
   input  logic                          dnan_i,
   output logic [OUT_EXP_W+OUT_FRAC_W:0] word_o,
   output logic                          invalid_o
);

   localparam int IN_W  = 1 + IN_EXP_W + IN_FRAC_W;
   localparam int OUT_W = 1 + OUT_EXP_W + OUT_FRAC_W;
   localparam int LZW   = $clog2(IN_FRAC_W + 1);
   localparam int BD    = bias_of(OUT_EXP_W) - bias_of(IN_EXP_W);

   generate
      if (OUT_EXP_W <= IN_EXP_W) begin : g_bad_exp
         $error("hcvt_widen: output exponent must be wider than input exponent");
      end
      if (OUT_FRAC_W < IN_FRAC_W) begin : g_bad_frac
         $error("hcvt_widen: output fraction narrower than input fraction");
      end
      if (BD <= IN_FRAC_W) begin : g_bad_range
         $error("hcvt_widen: output range cannot hold normalised subnormals");
      end
   endgenerate

   logic                  h_sign;
   logic [IN_EXP_W-1:0]   h_exp;
   logic [IN_FRAC_W-1:0]  h_frac;
   hcls_e                 h_cls;
   logic [LZW-1:0]        h_lz;
   logic                  h_fz;
   logic [OUT_W-1:0]      nxt_word;
   logic                  nxt_inv;

   hcvt_unpack #(.EXP_W(IN_EXP_W), .FRAC_W(IN_FRAC_W)) u_unpack (
      .half_i (half_i),
      .alt_i  (alt_i),
      .sign_o (h_sign),
      .exp_o  (h_exp),
      .frac_o (h_frac),
      .cls_o  (h_cls)
   );

   hcvt_lzc #(.W(IN_FRAC_W), .CW(LZW)) u_lzc (
      .vec_i  (h_frac),
      .cnt_o  (h_lz),
      .zero_o (h_fz)
   );

   hcvt_pack #(
      .IEW(IN_EXP_W), .IFW(IN_FRAC_W),
      .OEW(OUT_EXP_W), .OFW(OUT_FRAC_W), .LZW(LZW)
   ) u_pack (
      .sign_i    (h_sign),
      .exp_i     (h_exp),
      .frac_i    (h_frac),
      .cls_i     (h_cls),
      .lz_i      (h_lz),
      .dnan_i    (dnan_i),
      .word_o    (nxt_word),
      .invalid_o (nxt_inv)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_o    <= '0;
               invalid_o <= 1'b0;
            end else begin
               word_o    <= nxt_word;
               invalid_o <= nxt_inv;
            end
         end
      end else begin : g_comb
         assign word_o    = nxt_word;
         assign invalid_o = nxt_inv;
      end
   endgenerate

   // R5: alternative mode never produces an all-ones output exponent
   a_r5_alt_finite: assert property (@(posedge clk) disable iff (!rst_n)
      alt_i |-> (nxt_word[OUT_W-2 -: OUT_EXP_W] != {OUT_EXP_W{1'b1}}));

   // R3: a subnormal lands on a nonzero exponent no larger than the bias gap
   a_r3_sub_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cls == CLS_SUB) |-> ((nxt_word[OUT_W-2 -: OUT_EXP_W] != '0) &&
                              (nxt_word[OUT_W-2 -: OUT_EXP_W] <= OUT_EXP_W'(BD))));

   // R2: sign follows the input except for a default NaN
   a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(dnan_i && (h_cls == CLS_QNAN || h_cls == CLS_SNAN))
         |-> (nxt_word[OUT_W-1] == half_i[IN_W-1]));

   // R6: every NaN result is quiet
   a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cls == CLS_QNAN || h_cls == CLS_SNAN) |-> nxt_word[OUT_FRAC_W-1]);

   // R7: invalid only in IEEE mode, and only with a quiet NaN result
   a_r7_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_inv |-> (!alt_i && (&nxt_word[OUT_W-2 -: OUT_EXP_W]) && nxt_word[OUT_FRAC_W-1]));

   // R8: flag is never raised for a non-NaN input
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (h_cls != CLS_QNAN && h_cls != CLS_SNAN) |-> !nxt_inv);

endmodule

// File: tb/test_hcvt_widen.sv
`timescale 1ns/1ps
module test_hcvt_widen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] half_i = '0;
   logic        alt_i = 1'b0;
   logic        dnan_i = 1'b0;
   logic [31:0] word_o;
   logic        invalid_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hcvt_widen i_hcvt_widen (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_i    (half_i),
      .alt_i     (alt_i),
      .dnan_i    (dnan_i),
      .word_o    (word_o),
      .invalid_o (invalid_o)
   );

   // Bench model: {invalid, word}, normalising by iterative shifting
   function automatic logic [32:0] ref_conv(input logic [15:0] h, input logic alt,
                                             input logic dn);
      logic       s;
      logic [4:0] e;
      logic [9:0] f;
      s = h[15]; e = h[14:10]; f = h[9:0];
      if (e == 5'd31 && !alt) begin
         if (f == '0) return {1'b0, s, 8'hFF, 23'h0};
         if (dn) return {!f[9], 32'h7FC00000};
         return {!f[9], s, 8'hFF, 1'b1, f[8:0], 13'h0};
      end else if (e == 5'd0) begin
         int         ex;
         logic [10:0] m;
         if (f == '0) return {1'b0, s, 31'h0};
         ex = 113;
         m  = {1'b0, f};
         while (!m[10]) begin
            m  = m << 1;
            ex = ex - 1;
         end
         return {1'b0, s, 8'(ex), m[9:0], 13'h0};
      end
      return {1'b0, s, 8'(32'(e) + 32'd112), f, 13'h0};
   endfunction

   task automatic apply(input string tag, input logic [15:0] h, input logic alt,
                        input logic dn, input logic [32:0] exp_v);
      half_i = h; alt_i = alt; dnan_i = dn;
      @(posedge clk);
      @(negedge clk);
      n_vec++;
      if ({invalid_o, word_o} !== exp_v) begin
         n_bad++;
         $display("FAIL %s in=%h alt=%0d dn=%0d actual inv=%0d word=%h expected inv=%0d word=%h",
                  tag, h, alt, dn, invalid_o, word_o, exp_v[32], exp_v[31:0]);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      n_vec++;
      if (word_o !== 32'h0 || invalid_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R8 reset actual %h/%0d expected 00000000/0", word_o, invalid_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (word_o !== 32'h0 || invalid_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R8 post-reset actual %h/%0d expected 00000000/0", word_o, invalid_o);
      end
   endtask

   task automatic t_normals();
      apply("R1 one",        16'h3C00, 1'b0, 1'b0, {1'b0, 32'h3F800000});
      apply("R1 minus two",  16'hC000, 1'b0, 1'b0, {1'b0, 32'hC0000000});
      apply("R1 max ieee",   16'h7BFF, 1'b0, 1'b0, {1'b0, 32'h477FE000});
      apply("R1 min normal", 16'h0400, 1'b1, 1'b0, {1'b0, 32'h38800000});
   endtask

   task automatic t_zeros();
      apply("R2 +0",     16'h0000, 1'b0, 1'b0, {1'b0, 32'h00000000});
      apply("R2 -0",     16'h8000, 1'b0, 1'b1, {1'b0, 32'h80000000});
      apply("R2 -0 alt", 16'h8000, 1'b1, 1'b0, {1'b0, 32'h80000000});
   endtask

   task automatic t_subnormals();
      apply("R3 min sub",  16'h0001, 1'b0, 1'b0, {1'b0, 32'h33800000});
      apply("R3 max sub",  16'h03FF, 1'b0, 1'b0, {1'b0, 32'h387FC000});
      apply("R3 neg sub",  16'h8200, 1'b1, 1'b0, {1'b0, 32'hB8000000});
      apply("R3 mid sub",  16'h0010, 1'b0, 1'b0, {1'b0, 32'h35800000});
   endtask

   task automatic t_inf();
      apply("R4 +inf",    16'h7C00, 1'b0, 1'b0, {1'b0, 32'h7F800000});
      apply("R4 -inf dn", 16'hFC00, 1'b0, 1'b1, {1'b0, 32'hFF800000});
   endtask

   task automatic t_alt();
      apply("R5 alt max",  16'h7FFF, 1'b1, 1'b0, {1'b0, 32'h47FFE000});
      apply("R5 alt -e31", 16'hFC00, 1'b1, 1'b0, {1'b0, 32'hC7800000});
      apply("R5 alt q",    16'h7E00, 1'b1, 1'b1, {1'b0, 32'h47C00000});
      apply("R5 alt s",    16'h7C01, 1'b1, 1'b1, {1'b0, 32'h47802000});
   endtask

   task automatic t_qnan();
      apply("R6 qnan",     16'h7E00, 1'b0, 1'b0, {1'b0, 32'h7FC00000});
      apply("R6 qnan neg", 16'hFE55, 1'b0, 1'b0, {1'b0, 32'hFFCAA000});
      apply("R6 qnan dn",  16'hFE55, 1'b0, 1'b1, {1'b0, 32'h7FC00000});
   endtask

   task automatic t_snan();
      apply("R7 snan",     16'h7C01, 1'b0, 1'b0, {1'b1, 32'h7FC02000});
      apply("R7 snan neg", 16'hFD00, 1'b0, 1'b0, {1'b1, 32'hFFE00000});
      apply("R7 snan dn",  16'hFDFF, 1'b0, 1'b1, {1'b1, 32'h7FC00000});
   endtask

   task automatic t_sweep();
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 65536; c++) begin
            apply("R8 sweep", 16'(c), m[0], 1'b0, ref_conv(16'(c), m[0], 1'b0));
         end
      end
   endtask

   task automatic t_dn_sweep();
      for (int c = 0; c < 2048; c++) begin
         logic [15:0] h;
         h = {c[10], 5'h1F, c[9:0]};
         apply("R7 dn sweep", h, 1'b0, 1'b1, ref_conv(h, 1'b0, 1'b1));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_normals();
      t_zeros();
      t_subnormals();
      t_inf();
      t_alt();
      t_qnan();
      t_snan();
      t_sweep();
      t_dn_sweep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule